// File: doc/BRIEF.md
# Timer Host Register Interface

This block sits between a host bus and three independent down-counter cores of an interval timer. The host sees a four-location window. Locations 0, 1 and 2 are the data ports of counters 0, 1 and 2, in that order. Location 3 takes control words. The block decodes each control word in one of three ways: as a configuration for one counter (operating mode, byte access pattern and BCD flag), as a command that freezes a counter's count, or as a command that captures status. It turns byte writes into 16-bit load values with a one-cycle commit strobe. It turns byte reads of live or frozen counts into the right byte sequence.

The counter cores are not part of this block. Their running counts and output pin levels come in as inputs. The block drives load values, load strobes, per-channel mode and BCD settings, and a configuration strobe that tells a core it has been reprogrammed. Bus accesses are synchronous: a cycle with select and write (or read) high is one access. Read data is registered and is valid in the cycle after the read strobe.

Top module: `tmr_hostif`

## Requirements
- R1: After reset the read data, all load values, load strobes, configuration strobes, mode outputs and BCD outputs are zero.
- R2: A write to location 3 whose bits 7:6 name counter 0 to 2 and whose bits 5:4 are not 00 configures that counter. Its mode output becomes bits 3:1 and its BCD output becomes bit 0 after the write edge. Its configuration strobe, and only its strobe, is high for that one cycle.
- R3: A data write to a counter that has not yet received a configuration word produces no load strobe.
- R4: With access code 01 (low byte only), a data write commits {8'h00, byte}. With access code 10 (high byte only), it commits {byte, 8'h00}. The counter's load strobe is high for the one cycle after the write.
- R5: With access code 11 (low then high), the first data byte produces no load strobe. The second commits {second, first}.
- R6: A configuration word resets that counter's byte toggle, so a pending first byte is discarded and the next byte is taken as a low byte.
- R7: Reads of an unlatched counter return the live count. Access 01 returns the low byte and access 10 returns the high byte. Access 11 returns the low byte and the high byte alternately, starting with the low byte.
- R8: A control word with bits 5:4 equal to 00 (latch command) freezes the named counter's count. Reads return bytes of that snapshot until the last byte of the access pattern has been read, and then return the live count again.
- R9: A latch command issued while a snapshot is still unread is ignored.
- R10: A control word with bits 7:6 equal to 11 is a status command. Each of bits 0, 1 and 2 that is set captures the status byte of counter 0, 1 or 2: {OUT level, 0, access code, mode, BCD}. The next read of that counter returns the status byte and does not advance its byte toggle. Later reads return count bytes.
- R11: A read of location 3 returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Chip select, qualifies read and write |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe (wins over read) |
| busAddr | input | 2 | Location: 0-2 counters, 3 control |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Registered read data |
| liveCount | input | 48 | Running counts of the cores, counter 0 in bits 15:0 |
| outLevel | input | 3 | OUT pin level of each core |
| loadValue | output | 48 | Last committed 16-bit load value per counter |
| loadStrobe | output | 3 | One-cycle commit pulse per counter |
| modeOut | output | 9 | 3-bit operating mode per counter, counter 0 in bits 2:0 |
| bcdOut | output | 3 | BCD counting flag per counter |
| cfgStrobe | output | 3 | One-cycle pulse when a counter is reconfigured |

## Verification
The configuration decode is swept over every counter, every non-latch access code, every mode code and both BCD values. The sweep separates a wrong field position, a wrong counter select and a strobe that reaches the wrong channel. The load path is tried with spread byte values under each access code, which tells a swapped byte pair apart from a zero-filled half. A half-written pair interrupted by a new configuration word shows whether the toggle is reset. Snapshot reads are taken while the live count changes between bytes, with a second latch and a status capture mixed in. These sequences separate a snapshot that is frozen correctly from one that is refreshed, released too early or never released.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH    = 3;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;
  localparam int ADDR_W = $clog2(NCH + 1);

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_PAIR  = 2'b11
  } access_t;

  typedef struct packed {
    logic [NCH-1:0]    cfgWr;
    logic [NCH-1:0]    latchCmd;
    logic [NCH-1:0]    statusCmd;
    logic [NCH-1:0]    dataWr;
    logic [NCH-1:0]    dataRd;
    logic              ctrlRd;
    logic [BYTE_W-1:0] data;
  } ctrlStrobes_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              busSel,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  output ctrlStrobes_t      strb
);
  localparam logic [1:0] STAT_SEL = 2'b11;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NCH);

  logic       wrHit, rdHit, isCtrl;
  logic [1:0] selFld;
  access_t    accFld;

  assign wrHit  = busSel && busWr;
  assign rdHit  = busSel && busRd && !busWr;
  assign isCtrl = (busAddr == CTRL_ADDR);
  assign selFld = busWrData[7:6];
  assign accFld = access_t'(busWrData[5:4]);

  assign strb.ctrlRd = rdHit && isCtrl;
  assign strb.data   = busWrData;

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic selMe, addrMe;
    assign selMe  = (selFld == 2'(i));
    assign addrMe = (busAddr == ADDR_W'(i));
    assign strb.cfgWr[i]     = wrHit && isCtrl && selMe && (accFld != ACC_LATCH);
    assign strb.latchCmd[i]  = wrHit && isCtrl && selMe && (accFld == ACC_LATCH);
    assign strb.statusCmd[i] = wrHit && isCtrl && (selFld == STAT_SEL) && busWrData[i];
    assign strb.dataWr[i]    = wrHit && addrMe;
    assign strb.dataRd[i]    = rdHit && addrMe;
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strb,
  input  logic [NCH*CNT_W-1:0]   liveCount,
  input  logic [NCH-1:0]         outLevel,
  output logic [BYTE_W-1:0]      busRdData,
  output logic [NCH*CNT_W-1:0]   loadValue,
  output logic [NCH-1:0]         loadStrobe,
  output logic [NCH*MODE_W-1:0]  modeOut,
  output logic [NCH-1:0]         bcdOut,
  output logic [NCH-1:0]         cfgStrobe
);
  logic [BYTE_W-1:0] rdByte [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    access_t           acc;
    logic [MODE_W-1:0] mode;
    logic              bcd, cfgValid, wrPtr, rdPtr, latched, statHeld;
    logic              loadPulse, cfgPulse;
    logic [BYTE_W-1:0] lowHold, statByte, byteOut;
    logic [CNT_W-1:0]  live, snap, src, loadReg;

    assign live = liveCount[i*CNT_W +: CNT_W];
    assign src  = latched ? snap : live;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        acc       <= ACC_LATCH;
        mode      <= '0;
        bcd       <= 1'b0;
        cfgValid  <= 1'b0;
        wrPtr     <= 1'b0;
        rdPtr     <= 1'b0;
        latched   <= 1'b0;
        statHeld  <= 1'b0;
        lowHold   <= '0;
        statByte  <= '0;
        snap      <= '0;
        loadReg   <= '0;
        loadPulse <= 1'b0;
        cfgPulse  <= 1'b0;
      end else begin
        loadPulse <= 1'b0;
        cfgPulse  <= 1'b0;
        if (strb.cfgWr[i]) begin
          acc      <= access_t'(strb.data[5:4]);
          mode     <= strb.data[3:1];
          bcd      <= strb.data[0];
          cfgValid <= 1'b1;
          wrPtr    <= 1'b0;
          rdPtr    <= 1'b0;
          latched  <= 1'b0;
          statHeld <= 1'b0;
          cfgPulse <= 1'b1;
        end
        if (strb.latchCmd[i] && !latched) begin
          snap    <= live;
          latched <= 1'b1;
        end
        if (strb.statusCmd[i] && !statHeld) begin
          statByte <= {outLevel[i], 1'b0, acc, mode, bcd};
          statHeld <= 1'b1;
        end
        if (strb.dataWr[i] && cfgValid) begin
          unique case (acc)
            ACC_LO: begin
              loadReg   <= {{BYTE_W{1'b0}}, strb.data};
              loadPulse <= 1'b1;
            end
            ACC_HI: begin
              loadReg   <= {strb.data, {BYTE_W{1'b0}}};
              loadPulse <= 1'b1;
            end
            ACC_PAIR: begin
              if (!wrPtr) begin
                lowHold <= strb.data;
                wrPtr   <= 1'b1;
              end else begin
                loadReg   <= {strb.data, lowHold};
                loadPulse <= 1'b1;
                wrPtr     <= 1'b0;
              end
            end
            default: ;
          endcase
        end
        if (strb.dataRd[i]) begin
          if (statHeld) begin
            statHeld <= 1'b0;
          end else if (acc == ACC_PAIR) begin
            rdPtr <= !rdPtr;
            if (rdPtr) latched <= 1'b0;
          end else begin
            latched <= 1'b0;
          end
        end
      end
    end

    always_comb begin
      if (statHeld)            byteOut = statByte;
      else if (acc == ACC_HI)  byteOut = src[CNT_W-1:BYTE_W];
      else if (acc == ACC_PAIR && rdPtr) byteOut = src[CNT_W-1:BYTE_W];
      else                     byteOut = src[BYTE_W-1:0];
    end

    assign rdByte[i]                        = byteOut;
    assign loadValue[i*CNT_W +: CNT_W]      = loadReg;
    assign loadStrobe[i]                    = loadPulse;
    assign modeOut[i*MODE_W +: MODE_W]      = mode;
    assign bcdOut[i]                        = bcd;
    assign cfgStrobe[i]                     = cfgPulse;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdData <= '0;
    end else if (strb.ctrlRd) begin
      busRdData <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (strb.dataRd[i]) busRdData <= rdByte[i];
      end
    end
  end
endmodule

// File: rtl/tmr_hostif.sv
module tmr_hostif
  import tmr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busSel,
  input  logic                   busRd,
  input  logic                   busWr,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [BYTE_W-1:0]      busWrData,
  output logic [BYTE_W-1:0]      busRdData,
  input  logic [NCH*CNT_W-1:0]   liveCount,
  input  logic [NCH-1:0]         outLevel,
  output logic [NCH*CNT_W-1:0]   loadValue,
  output logic [NCH-1:0]         loadStrobe,
  output logic [NCH*MODE_W-1:0]  modeOut,
  output logic [NCH-1:0]         bcdOut,
  output logic [NCH-1:0]         cfgStrobe
);
  ctrlStrobes_t strb;

  tmr_ctrl u_ctrl (
    .busSel    (busSel),
    .busRd     (busRd),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .strb      (strb)
  );

  tmr_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .liveCount  (liveCount),
    .outLevel   (outLevel),
    .busRdData  (busRdData),
    .loadValue  (loadValue),
    .loadStrobe (loadStrobe),
    .modeOut    (modeOut),
    .bcdOut     (bcdOut),
    .cfgStrobe  (cfgStrobe)
  );
endmodule

// File: rtl/tmr_hostif_chk.sv
module tmr_hostif_chk
  import tmr_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   busSel,
  input logic                   busRd,
  input logic                   busWr,
  input logic [ADDR_W-1:0]      busAddr,
  input logic [BYTE_W-1:0]      busWrData,
  input logic [BYTE_W-1:0]      busRdData,
  input logic [NCH*CNT_W-1:0]   liveCount,
  input logic [NCH-1:0]         outLevel,
  input logic [NCH*CNT_W-1:0]   loadValue,
  input logic [NCH-1:0]         loadStrobe,
  input logic [NCH*MODE_W-1:0]  modeOut,
  input logic [NCH-1:0]         bcdOut,
  input logic [NCH-1:0]         cfgStrobe
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NCH);

  // R2: a configuration pulse follows a control write with non-latch access
  a_r2_cfg_from_ctrl_write: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStrobe != '0) |-> $past(busSel && busWr && busAddr == CTRL_ADDR && busWrData[5:4] != 2'b00));

  // R2: counter 0 takes mode and BCD bits of the word that configured it
  a_r2_mode_field: assert property (@(posedge clk) disable iff (!rstN)
    cfgStrobe[0] |-> (modeOut[MODE_W-1:0] == $past(busWrData[3:1]) && bcdOut[0] == $past(busWrData[0])));

  // R4: a commit follows only a data write to a counter location
  a_r4_load_from_data_write: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe != '0) |-> $past(busSel && busWr && busAddr != CTRL_ADDR));

  // R4: one bus access commits at most one counter
  a_r4_single_commit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadStrobe));

  // R11: control location reads as zero
  a_r11_ctrl_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(busSel && busRd && !busWr && busAddr == CTRL_ADDR) |-> (busRdData == '0));
endmodule

bind tmr_hostif tmr_hostif_chk u_chk (.*);

// File: tb/tmr_hostif_test.sv
`timescale 1ns/100ps
module tmr_hostif_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busRd = 1'b0, busWr = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [47:0] liveCount = '0;
  logic [2:0]  outLevel = '0;
  logic [47:0] loadValue;
  logic [2:0]  loadStrobe;
  logic [8:0]  modeOut;
  logic [2:0]  bcdOut;
  logic [2:0]  cfgStrobe;

  int checks = 0, fails = 0;
  logic [2:0]  gotStrobe, gotCfg;
  logic [47:0] gotLoad;
  logic [7:0]  gotRd;

  always #2.5 clk = ~clk;

  tmr_hostif uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrBus(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    gotStrobe = loadStrobe; gotLoad = loadValue; gotCfg = cfgStrobe;
  endtask

  task automatic rdBus(input logic [1:0] a);
    @(negedge clk);
    busSel = 1'b1; busRd = 1'b1; busAddr = a;
    @(negedge clk);
    busSel = 1'b0; busRd = 1'b0;
    gotRd = busRdData;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busRdData == 0 && loadValue == 0 && loadStrobe == 0 && cfgStrobe == 0
        && modeOut == 0 && bcdOut == 0, "R1 reset state", {busRdData, loadStrobe}, 0);
    rstN = 1'b1;

    // R3: count write before any configuration is dropped
    wrBus(2'd0, 8'h55);
    chk(gotStrobe == 0, "R3 unconfigured write", gotStrobe, 0);
    wrBus(2'd2, 8'h66);
    chk(gotStrobe == 0, "R3 unconfigured write ch2", gotStrobe, 0);

    // R11
    rdBus(2'd3);
    chk(gotRd == 0, "R11 control read", gotRd, 0);

    // R2: decode sweep
    for (int ch = 0; ch < 3; ch++)
      for (int ac = 1; ac < 4; ac++)
        for (int md = 0; md < 6; md++)
          for (int b = 0; b < 2; b++) begin
            wrBus(2'd3, 8'((ch << 6) | (ac << 4) | (md << 1) | b));
            chk(gotCfg == 3'(1 << ch), "R2 cfg strobe", gotCfg, 1 << ch);
            chk(modeOut[ch*3 +: 3] == 3'(md) && bcdOut[ch] == 1'(b), "R2 mode/bcd",
                {modeOut[ch*3 +: 3], bcdOut[ch]}, (md << 1) | b);
            chk(gotStrobe == 0, "R2 no load on cfg", gotStrobe, 0);
          end

    // Configure: ch0 low-only mode3, ch1 high-only mode4, ch2 pair mode2 bcd
    wrBus(2'd3, 8'h16);
    wrBus(2'd3, 8'h68);
    wrBus(2'd3, 8'hB5);

    // R4 sweep
    for (int d = 0; d < 256; d += 17) begin
      wrBus(2'd0, 8'(d));
      chk(gotStrobe == 3'b001 && gotLoad[15:0] == 16'(d), "R4 low-only load", gotLoad[15:0], d);
      wrBus(2'd1, 8'(d));
      chk(gotStrobe == 3'b010 && gotLoad[31:16] == 16'(d << 8), "R4 high-only load", gotLoad[31:16], d << 8);
    end

    // R5 pair sweep
    for (int k = 0; k < 16; k++) begin
      wrBus(2'd2, 8'(k * 13 + 1));
      chk(gotStrobe == 0, "R5 first byte no commit", gotStrobe, 0);
      wrBus(2'd2, 8'(255 - k * 7));
      chk(gotStrobe == 3'b100 && gotLoad[47:32] == {8'(255 - k * 7), 8'(k * 13 + 1)},
          "R5 pair commit", gotLoad[47:32], {8'(255 - k * 7), 8'(k * 13 + 1)});
    end

    // R6: reconfiguration drops a pending low byte
    wrBus(2'd2, 8'hAA);
    wrBus(2'd3, 8'hB5);
    wrBus(2'd2, 8'h12);
    chk(gotStrobe == 0, "R6 toggle reset first byte", gotStrobe, 0);
    wrBus(2'd2, 8'h34);
    chk(gotLoad[47:32] == 16'h3412 && gotStrobe == 3'b100, "R6 toggle reset commit", gotLoad[47:32], 16'h3412);

    // R7 live reads
    liveCount = {16'hC3D4, 16'hA1B2, 16'h9F8E};
    rdBus(2'd0); chk(gotRd == 8'h8E, "R7 low-only read", gotRd, 8'h8E);
    rdBus(2'd1); chk(gotRd == 8'hA1, "R7 high-only read", gotRd, 8'hA1);
    rdBus(2'd2); chk(gotRd == 8'hD4, "R7 pair read low", gotRd, 8'hD4);
    rdBus(2'd2); chk(gotRd == 8'hC3, "R7 pair read high", gotRd, 8'hC3);
    rdBus(2'd2); chk(gotRd == 8'hD4, "R7 pair read wraps", gotRd, 8'hD4);
    rdBus(2'd2);

    // R8 / R9 latch on ch2
    liveCount[47:32] = 16'h1234;
    wrBus(2'd3, 8'h80);
    liveCount[47:32] = 16'hABCD;
    rdBus(2'd2); chk(gotRd == 8'h34, "R8 snapshot low", gotRd, 8'h34);
    wrBus(2'd3, 8'h80);
    liveCount[47:32] = 16'h5566;
    rdBus(2'd2); chk(gotRd == 8'h12, "R9 second latch ignored", gotRd, 8'h12);
    rdBus(2'd2); chk(gotRd == 8'h66, "R8 released to live", gotRd, 8'h66);
    rdBus(2'd2);

    // R8 latch on ch0 (single byte)
    liveCount[15:0] = 16'h0077;
    wrBus(2'd3, 8'h00);
    liveCount[15:0] = 16'h0099;
    rdBus(2'd0); chk(gotRd == 8'h77, "R8 single-byte snapshot", gotRd, 8'h77);
    rdBus(2'd0); chk(gotRd == 8'h99, "R8 single-byte release", gotRd, 8'h99);

    // R10 status capture on ch0 and ch2
    outLevel = 3'b101;
    wrBus(2'd3, 8'hC5);
    outLevel = 3'b000;
    rdBus(2'd0); chk(gotRd == 8'h96, "R10 status ch0", gotRd, 8'h96);
    rdBus(2'd0); chk(gotRd == 8'h99, "R10 count after status ch0", gotRd, 8'h99);
    rdBus(2'd1); chk(gotRd == 8'hA1, "R10 unselected ch1 count", gotRd, 8'hA1);
    rdBus(2'd2); chk(gotRd == 8'hB5, "R10 status ch2", gotRd, 8'hB5);
    rdBus(2'd2); chk(gotRd == 8'h66, "R10 toggle kept low", gotRd, 8'h66);
    rdBus(2'd2); chk(gotRd == 8'h55, "R10 toggle then high", gotRd, 8'h55);

    rdBus(2'd3);
    chk(gotRd == 0, "R11 control read late", gotRd, 0);

    summary();
  end
endmodule